// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break and False-Start Handling

This block turns a single serial input line into characters. It runs from the system clock. A separate sample enable marks the instants at which the line is looked at. In 16X mode every bit spans sixteen enables, and the receiver samples each bit near its centre. In 1X mode every enable carries exactly one bit.

Configuration inputs set the following:
- the character length, from five to eight bits;
- the parity rule;
- a compare value.

Each delivered character comes with three flags: parity error, framing error and compare match. A line held low through a whole frame is reported as a break. The block gives a pulse when the break begins and another when the line recovers. No character is delivered for a break.

Two recovery rules keep the receiver in step in 16X mode:
- A start edge that does not last to mid-bit is dropped.
- After a bad stop bit, the receiver waits half a bit time before it looks for the next start.

Configuration is expected to stay constant while a frame is in progress.

Top module: `arx_async_rx`

## Requirements
- R1: While `rst` is high, `chr_vld`, `chr_data`, `chr_perr`, `chr_ferr`, `chr_match`, `brk_start` and `brk_end` are all 0.
- R2: In 16X mode a frame is one low start bit, then N data bits least significant first, then an optional parity bit, then one stop bit. Each bit lasts 16 enables, and N = 5 + `cfg_len` (`cfg_len` 0..3 gives 5..8). The character appears on `chr_data` together with a one-cycle `chr_vld` pulse. Bits at positions N and above read 0.
- R3: `cfg_par` selects the parity rule: 0 = none, 1 = even, 2 = odd, 3 = forced to the level on `cfg_par_lvl`. With 0 there is no parity bit and `chr_perr` is 0. Otherwise `chr_perr` is 1 when the received parity bit differs from the expected bit. For even parity the expected bit makes the count of ones in data and parity even. For odd parity it makes that count odd.
- R4: In 16X mode the start bit is confirmed at the 8th enable after the falling edge is first seen. If the line is high again by then, no character and no break are produced.
- R5: A frame whose stop bit samples low, and which is not a break, is delivered with `chr_ferr` = 1.
- R6: In 16X mode, after a framing error the search for a start bit resumes 8 enables after the stop-bit sample. A low stop bit that runs straight into the next frame's start bit therefore still yields the correct next character.
- R7: A frame whose data bits, parity bit (when present) and stop bit are all 0 is a break. It raises `brk_start` for one cycle and does not raise `chr_vld`.
- R8: After a break, `brk_end` pulses once on the first enable at which the line is high. No further break pulse occurs while the line stays low.
- R9: `chr_match` is 1 with a character when its N data bits equal the low N bits of `cfg_cmp`.
- R10: In 1X mode (`cfg_x16` = 0) a low line at any enable is taken as a start bit, with no false-start rejection, and each following enable samples the next bit.
- R11: Only clock cycles with `samp_en` = 1 advance the receiver. Spacing the enables apart does not change the received character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_en | input | 1 | Line sample enable (16 or 1 per bit) |
| rxd | input | 1 | Serial data line, idle high, already synchronised |
| cfg_x16 | input | 1 | 1 = 16X sampling, 0 = 1X sampling |
| cfg_len | input | 2 | Character length minus five |
| cfg_par | input | 2 | Parity rule: 0 none, 1 even, 2 odd, 3 forced |
| cfg_par_lvl | input | 1 | Expected parity level in forced mode |
| cfg_cmp | input | 8 | Compare value for the match flag |
| chr_vld | output | 1 | One-cycle pulse: new character available |
| chr_data | output | 8 | Received character, upper unused bits zero |
| chr_perr | output | 1 | Parity error for the character |
| chr_ferr | output | 1 | Framing error for the character |
| chr_match | output | 1 | Character equals the compare value |
| brk_start | output | 1 | One-cycle pulse: break detected |
| brk_end | output | 1 | One-cycle pulse: line returned high after a break |

## Verification
A framing error and a compare match can be reported in the same `chr_vld` cycle. The bench provokes this with a character equal to `cfg_cmp` whose stop bit is low, and expects both flags set together. That low stop bit then runs straight into the next frame's start bit. The correct decoding of that next frame shows that the half-bit resynchronisation did not disturb the flagged character.

The bench also sends a break while `cfg_cmp` is zero, which is where a match and a break could clash. It expects a `brk_start` pulse only, with no character and hence no match.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int CHAR_W  = 8;
    localparam int MIN_LEN = 5;
    localparam int IDX_W   = $clog2(CHAR_W);

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_FORCE = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_RESYNC,
        ST_BRK
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_bit;
        logic              stop_bit;
        logic              brk;
    } frame_t;

    // Mask that keeps the low (MIN_LEN + sel) bits of a character.
    function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] sel);
        logic [CHAR_W-1:0] m;
        for (int i = 0; i < CHAR_W; i++) begin
            m[i] = (i < MIN_LEN + int'(sel));
        end
        return m;
    endfunction

    // Parity bit the sender should have placed after the data bits.
    function automatic logic want_parity(input logic [CHAR_W-1:0] data,
                                         input par_mode_e        mode,
                                         input logic             lvl);
        case (mode)
            PAR_EVEN:  return ^data;
            PAR_ODD:   return ~^data;
            PAR_FORCE: return lvl;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/arx_frame_fsm.sv
module arx_frame_fsm
    import arx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       samp_en,
    input  logic       rxd,
    input  logic       x16,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    output frame_t     frm,
    output logic       frm_vld,
    output logic       brk_gone
);

    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [IDX_W-1:0]  bidx;
    logic [CHAR_W-1:0] shreg;
    logic              pbit;
    logic              tick;
    logic              last_bit;
    logic              mid_hit;
    logic              line_brk;

    always_comb begin
        tick     = x16 ? (cnt == CW'(OVS - 1)) : 1'b1;
        mid_hit  = (cnt == CW'(HALF - 1));
        last_bit = (bidx == IDX_W'(MIN_LEN - 1) + IDX_W'(len_sel));
        line_brk = !rxd && (shreg == '0) && !(par_en && pbit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            pbit     <= 1'b0;
            frm      <= '0;
            frm_vld  <= 1'b0;
            brk_gone <= 1'b0;
        end else begin
            frm_vld  <= 1'b0;
            brk_gone <= 1'b0;
            if (samp_en) begin
                case (state)
                    ST_IDLE: begin
                        if (!rxd) begin
                            shreg <= '0;
                            bidx  <= '0;
                            pbit  <= 1'b0;
                            if (x16) begin
                                cnt   <= CW'(1);
                                state <= ST_START;
                            end else begin
                                cnt   <= '0;
                                state <= ST_DATA;
                            end
                        end
                    end
                    ST_START: begin
                        if (mid_hit) begin
                            cnt   <= '0;
                            state <= rxd ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_DATA: begin
                        if (tick) begin
                            cnt         <= '0;
                            shreg[bidx] <= rxd;
                            bidx        <= bidx + IDX_W'(1);
                            if (last_bit) state <= par_en ? ST_PAR : ST_STOP;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_PAR: begin
                        if (tick) begin
                            cnt   <= '0;
                            pbit  <= rxd;
                            state <= ST_STOP;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_STOP: begin
                        if (tick) begin
                            cnt          <= '0;
                            frm_vld      <= 1'b1;
                            frm.data     <= shreg;
                            frm.par_bit  <= pbit;
                            frm.stop_bit <= rxd;
                            frm.brk      <= line_brk;
                            if (line_brk)       state <= ST_BRK;
                            else if (!rxd && x16) state <= ST_RESYNC;
                            else                state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_RESYNC: begin
                        if (mid_hit) begin
                            cnt   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    ST_BRK: begin
                        if (rxd) begin
                            brk_gone <= 1'b1;
                            state    <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R11: without an enable nothing in the receiver moves
    p_freeze_r11: assert property (@(posedge clk) disable iff (rst)
        !samp_en |=> ($stable(state) && $stable(cnt) && $stable(bidx)));

    // R8: end of break only follows a high line at an enable
    p_brk_gone_line_r8: assert property (@(posedge clk) disable iff (rst)
        brk_gone |-> ($past(rxd) && $past(samp_en)));

    // R4: a frame is only produced from a sampled stop bit
    p_frame_on_enable_r4: assert property (@(posedge clk) disable iff (rst)
        frm_vld |-> $past(samp_en));

endmodule

// File: rtl/arx_char_eval.sv
module arx_char_eval
    import arx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  frame_t            frm,
    input  logic              frm_vld,
    input  logic              brk_gone,
    input  logic [1:0]        len_sel,
    input  par_mode_e         par_mode,
    input  logic              par_lvl,
    input  logic [CHAR_W-1:0] cmp,
    output logic              chr_vld,
    output logic [CHAR_W-1:0] chr_data,
    output logic              chr_perr,
    output logic              chr_ferr,
    output logic              chr_match,
    output logic              brk_start,
    output logic              brk_end
);

    logic [CHAR_W-1:0] mask;
    logic [CHAR_W-1:0] kept;
    logic              exp_par;

    always_comb begin
        mask    = len_mask(len_sel);
        kept    = frm.data & mask;
        exp_par = want_parity(kept, par_mode, par_lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chr_vld   <= 1'b0;
            chr_data  <= '0;
            chr_perr  <= 1'b0;
            chr_ferr  <= 1'b0;
            chr_match <= 1'b0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
        end else begin
            chr_vld   <= frm_vld && !frm.brk;
            brk_start <= frm_vld && frm.brk;
            brk_end   <= brk_gone;
            if (frm_vld && !frm.brk) begin
                chr_data  <= kept;
                chr_perr  <= (par_mode != PAR_NONE) && (frm.par_bit != exp_par);
                chr_ferr  <= !frm.stop_bit;
                chr_match <= ((frm.data ^ cmp) & mask) == '0;
            end
        end
    end

    // R2: a character strobe lasts exactly one cycle
    p_vld_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        chr_vld |=> !chr_vld);

    // R7: a break never delivers a character
    p_brk_no_char_r7: assert property (@(posedge clk) disable iff (rst)
        brk_start |-> !chr_vld);

    // R8: break start and break end cannot coincide
    p_brk_order_r8: assert property (@(posedge clk) disable iff (rst)
        brk_end |-> !brk_start);

    // R2: bits beyond the programmed length stay zero (config held steady)
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (chr_vld && $stable(len_sel)) |-> ((chr_data & ~len_mask(len_sel)) == '0));

endmodule

// File: rtl/arx_async_rx.sv
module arx_async_rx
    import arx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_en,
    input  logic              rxd,
    input  logic              cfg_x16,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_par_lvl,
    input  logic [CHAR_W-1:0] cfg_cmp,
    output logic              chr_vld,
    output logic [CHAR_W-1:0] chr_data,
    output logic              chr_perr,
    output logic              chr_ferr,
    output logic              chr_match,
    output logic              brk_start,
    output logic              brk_end
);

    frame_t    frm;
    logic      frm_vld;
    logic      brk_gone;
    par_mode_e par_mode;

    assign par_mode = par_mode_e'(cfg_par);

    arx_frame_fsm #(.OVS(OVS)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .samp_en  (samp_en),
        .rxd      (rxd),
        .x16      (cfg_x16),
        .len_sel  (cfg_len),
        .par_en   (par_mode != PAR_NONE),
        .frm      (frm),
        .frm_vld  (frm_vld),
        .brk_gone (brk_gone)
    );

    arx_char_eval u_eval (
        .clk       (clk),
        .rst       (rst),
        .frm       (frm),
        .frm_vld   (frm_vld),
        .brk_gone  (brk_gone),
        .len_sel   (cfg_len),
        .par_mode  (par_mode),
        .par_lvl   (cfg_par_lvl),
        .cmp       (cfg_cmp),
        .chr_vld   (chr_vld),
        .chr_data  (chr_data),
        .chr_perr  (chr_perr),
        .chr_ferr  (chr_ferr),
        .chr_match (chr_match),
        .brk_start (brk_start),
        .brk_end   (brk_end)
    );

    // R9: the match flag is only meaningful alongside a character
    p_match_needs_char_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(chr_match) |-> chr_vld);

endmodule

// File: tb/arx_async_rx_test.sv
module arx_async_rx_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       samp_en;
    logic       rxd;
    logic       cfg_x16;
    logic [1:0] cfg_len;
    logic [1:0] cfg_par;
    logic       cfg_par_lvl;
    logic [7:0] cfg_cmp;
    logic       chr_vld;
    logic [7:0] chr_data;
    logic       chr_perr;
    logic       chr_ferr;
    logic       chr_match;
    logic       brk_start;
    logic       brk_end;

    always #10 clk = ~clk;

    arx_async_rx uut (
        .clk(clk), .rst(rst), .samp_en(samp_en), .rxd(rxd),
        .cfg_x16(cfg_x16), .cfg_len(cfg_len), .cfg_par(cfg_par),
        .cfg_par_lvl(cfg_par_lvl), .cfg_cmp(cfg_cmp),
        .chr_vld(chr_vld), .chr_data(chr_data), .chr_perr(chr_perr),
        .chr_ferr(chr_ferr), .chr_match(chr_match),
        .brk_start(brk_start), .brk_end(brk_end)
    );

    int checks = 0;
    int fails  = 0;
    int n_vld  = 0;
    int n_bs   = 0;
    int n_be   = 0;
    logic [7:0] c_data;
    logic c_perr, c_ferr, c_match;

    always @(negedge clk) begin
        if (!rst) begin
            if (chr_vld) begin
                n_vld++;
                c_data  = chr_data;
                c_perr  = chr_perr;
                c_ferr  = chr_ferr;
                c_match = chr_match;
            end
            if (brk_start) n_bs++;
            if (brk_end)   n_be++;
        end
    end

    typedef struct packed {
        logic [1:0] len;
        logic [1:0] par;
        logic       lvl;
        logic [7:0] cmp;
        logic [7:0] dat;
        logic       pbit;
        logic       stop;
        logic [7:0] e_dat;
        logic       e_perr;
        logic       e_ferr;
        logic       e_match;
    } vec_t;

    localparam vec_t VEC [0:8] = '{
        '{2'd3, 2'd0, 1'b0, 8'h00, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0},
        '{2'd3, 2'd1, 1'b0, 8'hA5, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b1},
        '{2'd3, 2'd2, 1'b0, 8'h00, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0},
        '{2'd0, 2'd1, 1'b0, 8'hF3, 8'hF3, 1'b1, 1'b1, 8'h13, 1'b0, 1'b0, 1'b1},
        '{2'd1, 2'd2, 1'b0, 8'h00, 8'h2A, 1'b1, 1'b1, 8'h2A, 1'b1, 1'b0, 1'b0},
        '{2'd2, 2'd3, 1'b1, 8'h00, 8'h55, 1'b1, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0},
        '{2'd2, 2'd3, 1'b0, 8'h7F, 8'h7F, 1'b1, 1'b1, 8'h7F, 1'b1, 1'b0, 1'b1},
        '{2'd3, 2'd0, 1'b0, 8'h3C, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b1},
        '{2'd3, 2'd0, 1'b0, 8'h00, 8'h81, 1'b0, 1'b1, 8'h81, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic en_step(input int gap);
        samp_en = 1'b1;
        @(negedge clk);
        if (gap > 0) begin
            samp_en = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic send_bit(input logic b, input int n_en, input int gap);
        rxd = b;
        repeat (n_en) en_step(gap);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nbits, input logic use_par,
                              input logic pb, input logic stp, input int ben, input int gap);
        send_bit(1'b0, ben, gap);
        for (int b = 0; b < nbits; b++) send_bit(d[b], ben, gap);
        if (use_par) send_bit(pb, ben, gap);
        send_bit(stp, ben, gap);
        samp_en = 1'b0;
    endtask

    task automatic idle(input int n);
        send_bit(1'b1, n, 0);
        samp_en = 1'b0;
    endtask

    task automatic expect_char(input string tag, input int nv0, input logic [7:0] d,
                               input logic pe, input logic fe, input logic m);
        chk(n_vld == nv0 + 1, {tag, " count"}, n_vld, nv0 + 1);
        chk(c_data == d,      {tag, " data"},  c_data, d);
        chk(c_perr == pe,     {tag, " perr"},  c_perr, pe);
        chk(c_ferr == fe,     {tag, " ferr"},  c_ferr, fe);
        chk(c_match == m,     {tag, " match"}, c_match, m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int   nv0, nb0, ne0;
        vec_t v;
        rst = 1'b1; samp_en = 1'b0; rxd = 1'b1; cfg_x16 = 1'b1;
        cfg_len = 2'd3; cfg_par = 2'd0; cfg_par_lvl = 1'b0; cfg_cmp = 8'h00;
        repeat (4) @(negedge clk);
        // R1: reset state of every output
        chk({chr_vld, chr_data, chr_perr, chr_ferr, chr_match, brk_start, brk_end} == '0,
            "R1 reset outputs", {chr_vld, chr_data, chr_perr, chr_ferr, chr_match}, 0);
        rst = 1'b0;
        idle(20);

        // Vector table: R2 lengths, R3 parity, R5 ferr, R6 resync, R9 match
        for (int i = 0; i <= 8; i++) begin
            v = VEC[i];
            cfg_len = v.len; cfg_par = v.par; cfg_par_lvl = v.lvl; cfg_cmp = v.cmp;
            nv0 = n_vld;
            send_frame(v.dat, 5 + int'(v.len), v.par != 2'd0, v.pbit, v.stop, 16, 0);
            repeat (3) @(negedge clk);
            expect_char($sformatf("R2/R3/R5/R6/R9 vec%0d", i), nv0,
                        v.e_dat, v.e_perr, v.e_ferr, v.e_match);
        end
        idle(20);

        // R4: short low pulse is a false start
        cfg_len = 2'd3; cfg_par = 2'd0; cfg_cmp = 8'h00;
        nv0 = n_vld; nb0 = n_bs;
        send_bit(1'b0, 5, 0);
        idle(40);
        chk(n_vld == nv0, "R4 false start no char", n_vld, nv0);
        chk(n_bs == nb0,  "R4 false start no break", n_bs, nb0);
        nv0 = n_vld;
        send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b1, 16, 0);
        idle(10);
        expect_char("R4 recover after false start", nv0, 8'h5A, 1'b0, 1'b0, 1'b0);

        // R7/R8: break with compare value zero
        nv0 = n_vld; nb0 = n_bs; ne0 = n_be;
        send_frame(8'h00, 8, 1'b0, 1'b0, 1'b0, 16, 0);
        send_bit(1'b0, 40, 0);
        samp_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(n_bs == nb0 + 1, "R7 break start once", n_bs, nb0 + 1);
        chk(n_vld == nv0,    "R7 break no char", n_vld, nv0);
        chk(n_be == ne0,     "R8 no end while low", n_be, ne0);
        idle(3);
        repeat (3) @(negedge clk);
        chk(n_be == ne0 + 1, "R8 break end on high", n_be, ne0 + 1);
        idle(20);

        // R11: enables spaced two cycles apart
        cfg_par = 2'd1;
        nv0 = n_vld;
        send_frame(8'hC3, 8, 1'b1, 1'b0, 1'b1, 16, 2);
        idle(10);
        expect_char("R11 spaced enables", nv0, 8'hC3, 1'b0, 1'b0, 1'b0);

        // R10: 1X mode, one enable per bit
        cfg_x16 = 1'b0; cfg_par = 2'd2;
        nv0 = n_vld;
        send_frame(8'h96, 8, 1'b1, 1'b1, 1'b1, 1, 0);
        idle(4);
        repeat (3) @(negedge clk);
        expect_char("R10 1X frame", nv0, 8'h96, 1'b0, 1'b0, 1'b0);
        cfg_par = 2'd0;
        nv0 = n_vld;
        send_bit(1'b0, 1, 0);
        idle(12);
        repeat (3) @(negedge clk);
        expect_char("R10 1X short low taken as start", nv0, 8'hFF, 1'b0, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule